// File: doc/BRIEF.md
# Prioritized Trap Interrupt Pending Unit

This block keeps the pending interrupt sources of a processor core and picks the one trap the core should take next. There are seven interrupt classes, and each class holds a 64-bit pending vector. Writers set or reset one bit at a time by giving a class number and a bit index. A clear-all strobe empties every vector at once. A read port returns the vector of any class, and a per-class summary shows which vectors are non-empty.

The trap choice is combinational. It is made from the registered vectors, the hypervisor-privilege flag and the interrupt-enable flag. In hypervisor mode only the tick-match and interrupt-vector classes can win, and only when the enable is high. In the other mode, three classes win regardless of the enable. The remaining four win only when the enable is high. When a software interrupt is selected, the block also outputs a 4-bit level taken from that class's vector.

Class numbers: 0 trap-level-zero, 1 tick match, 2 interrupt vector, 3 CPU mondo, 4 device mondo, 5 software interrupt, 6 resumable error.

Top module: `trap_pending_unit`

## Requirements
- R1: A post with a legal class (0..6) and index (0..63) sets that bit of the class vector. From the next cycle, `rd_vec` shows the bit and the class's bit of `summary` (bit n = class n) is 1.
- R2: A clear resets one bit. The class summary bit drops only when the whole class vector has become zero.
- R3: Clear-all and synchronous reset zero every vector and every summary bit. Clear-all overrides a post or clear issued in the same cycle.
- R4: When a post and a clear target the same bit in the same cycle, the bit ends up set.
- R5: A post or clear with class 7 or with index 64 or more changes nothing. Reading class 7 returns zero.
- R6: `any_pend` is 1 exactly when some summary bit is 1, whatever the values of `hpriv` and `int_en`.
- R7: With `hpriv`=1 and `int_en`=0, no trap is raised. With `hpriv`=1 and `int_en`=1, tick match (code 2) beats interrupt vector (code 3), and no other class is raised.
- R8: With `hpriv`=0, the order is trap-level-zero (code 1), tick match (code 2), then interrupt vector (code 3), whatever `int_en` is. Only with `int_en`=1 does the order go on to CPU mondo (4), device mondo (5), software interrupt (6) and resumable error (7).
- R9: While the code is 6, `sw_level` is 14 if bit 0 or bit 16 of the software vector is set. Otherwise it is the index of the highest set bit among bits 15..1, or 0 if none of those is set. While the code is not 6, `sw_level` is 0.
- R10: `trap_code` is 0 when no trap is raised, and `trap_vld` is 1 exactly when `trap_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_en | input | 1 | Post strobe |
| post_cls | input | 3 | Class to post |
| post_idx | input | 7 | Bit index to post |
| clr_en | input | 1 | Clear strobe |
| clr_cls | input | 3 | Class to clear |
| clr_idx | input | 7 | Bit index to clear |
| clr_all | input | 1 | Clear every vector |
| hpriv | input | 1 | Hypervisor-privilege mode |
| int_en | input | 1 | Interrupt enable |
| rd_cls | input | 3 | Class to read |
| rd_vec | output | 64 | Vector of the class being read |
| summary | output | 7 | Per-class non-empty flags |
| any_pend | output | 1 | Some class is pending |
| trap_vld | output | 1 | A trap is requested |
| trap_code | output | 3 | Selected trap, 0 for none |
| sw_level | output | 4 | Software interrupt level |

## Verification
The hardest cases to reach are those where several classes are pending at once and the mode inputs decide the winner. This includes the case where a gated class is pending but no trap is raised. A table loads a chosen set of classes, applies a privilege and enable pair, and checks the code. The software level mapping needs specific multi-bit patterns in one vector, such as bit 16 alongside higher-indexed low bits, or only bit 17. A second table builds these patterns bit by bit through posts. Same-cycle post and clear collisions are driven directly.

// File: rtl/trap_pending_unit.sv
module trap_pending_unit #(
  parameter int NCLS  = 7,
  parameter int VEC_W = 64,
  parameter int CLS_W = 3,
  parameter int IDX_W = 7,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             post_en,
  input  logic [CLS_W-1:0] post_cls,
  input  logic [IDX_W-1:0] post_idx,
  input  logic             clr_en,
  input  logic [CLS_W-1:0] clr_cls,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  input  logic             hpriv,
  input  logic             int_en,
  input  logic [CLS_W-1:0] rd_cls,
  output logic [VEC_W-1:0] rd_vec,
  output logic [NCLS-1:0]  summary,
  output logic             any_pend,
  output logic             trap_vld,
  output logic [CLS_W-1:0] trap_code,
  output logic [LVL_W-1:0] sw_level
);
  localparam int BIT_W  = $clog2(VEC_W);
  localparam int C_TLZ  = 0;
  localparam int C_TICK = 1;
  localparam int C_IVEC = 2;
  localparam int C_SW   = 5;

  logic [VEC_W-1:0] vec_q [NCLS];
  logic [LVL_W-1:0] lvl;

  wire post_ok = post_en && (post_cls < CLS_W'(NCLS)) && (post_idx < IDX_W'(VEC_W));
  wire clr_ok  = clr_en  && (clr_cls  < CLS_W'(NCLS)) && (clr_idx  < IDX_W'(VEC_W));

  for (genvar g = 0; g < NCLS; g++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst || clr_all) begin
        vec_q[g] <= '0;
      end else begin
        if (clr_ok && clr_cls == CLS_W'(g))
          vec_q[g][clr_idx[BIT_W-1:0]] <= 1'b0;
        if (post_ok && post_cls == CLS_W'(g))
          vec_q[g][post_idx[BIT_W-1:0]] <= 1'b1;
      end
    end
    assign summary[g] = |vec_q[g];
  end

  assign any_pend = |summary;
  assign rd_vec   = (rd_cls < CLS_W'(NCLS)) ? vec_q[rd_cls] : '0;

  always_comb begin
    trap_code = '0;
    if (hpriv) begin
      if (int_en) begin
        if (summary[C_TICK])      trap_code = CLS_W'(C_TICK + 1);
        else if (summary[C_IVEC]) trap_code = CLS_W'(C_IVEC + 1);
      end
    end else if (summary[C_TLZ]) begin
      trap_code = CLS_W'(C_TLZ + 1);
    end else if (summary[C_TICK]) begin
      trap_code = CLS_W'(C_TICK + 1);
    end else if (summary[C_IVEC]) begin
      trap_code = CLS_W'(C_IVEC + 1);
    end else if (int_en) begin
      for (int c = NCLS - 1; c > C_IVEC; c--)
        if (summary[c]) trap_code = CLS_W'(c + 1);
    end
  end

  assign trap_vld = trap_code != '0;

  always_comb begin
    lvl = '0;
    if (vec_q[C_SW][0] || vec_q[C_SW][16]) begin
      lvl = LVL_W'(14);
    end else begin
      for (int i = 1; i < 16; i++)
        if (vec_q[C_SW][i]) lvl = LVL_W'(i);
    end
  end

  assign sw_level = (trap_code == CLS_W'(C_SW + 1)) ? lvl : '0;

  // R1
  post_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (post_ok && !clr_all) |=> summary[$past(post_cls)]);
  // R3
  clear_all_chk: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> !any_pend);
  // R5
  illegal_post_chk: assert property (@(posedge clk) disable iff (rst)
    (post_en && !post_ok && !clr_en && !clr_all) |=> $stable(summary));
  // R7
  hyp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (hpriv && !int_en) |-> !trap_vld);
  // R7
  hyp_class_chk: assert property (@(posedge clk) disable iff (rst)
    hpriv |-> (trap_code == 3'd0 || trap_code == 3'd2 || trap_code == 3'd3));
  // R6
  vld_pend_chk: assert property (@(posedge clk) disable iff (rst)
    trap_vld |-> any_pend);
endmodule

// File: tb/sim_trap_pending_unit.sv
`timescale 1ns/1ps
module sim_trap_pending_unit;
  logic clk = 0, rst = 1;
  logic post_en = 0, clr_en = 0, clr_all = 0, hpriv = 0, int_en = 0;
  logic [2:0] post_cls = 0, clr_cls = 0, rd_cls = 0;
  logic [6:0] post_idx = 0, clr_idx = 0;
  logic [63:0] rd_vec;
  logic [6:0] summary;
  logic any_pend, trap_vld;
  logic [2:0] trap_code;
  logic [3:0] sw_level;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  trap_pending_unit u0 (.*);

  // {hpriv, int_en, class mask, expected code}
  localparam logic [11:0] PRI [14] = '{
    {1'b0,1'b0,7'h7F,3'd1}, {1'b0,1'b0,7'h7E,3'd2}, {1'b0,1'b0,7'h7C,3'd3},
    {1'b0,1'b0,7'h78,3'd0}, {1'b0,1'b1,7'h78,3'd4}, {1'b0,1'b1,7'h70,3'd5},
    {1'b0,1'b1,7'h60,3'd6}, {1'b0,1'b1,7'h40,3'd7}, {1'b0,1'b1,7'h7F,3'd1},
    {1'b1,1'b0,7'h7F,3'd0}, {1'b1,1'b1,7'h7F,3'd2}, {1'b1,1'b1,7'h7D,3'd3},
    {1'b1,1'b1,7'h79,3'd0}, {1'b0,1'b1,7'h00,3'd0}};
  // {software vector bits 17..0, expected level}
  localparam logic [21:0] LVL [8] = '{
    {18'h00001,4'd14}, {18'h10000,4'd14}, {18'h10002,4'd14}, {18'h08000,4'd15},
    {18'h0000A,4'd3},  {18'h00002,4'd1},  {18'h20000,4'd0},  {18'h04108,4'd14}};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op(logic pe, logic [2:0] pc, logic [6:0] pi,
                    logic ce, logic [2:0] cc, logic [6:0] ci, logic ca);
    @(negedge clk);
    post_en = pe; post_cls = pc; post_idx = pi;
    clr_en = ce; clr_cls = cc; clr_idx = ci; clr_all = ca;
    @(negedge clk);
    post_en = 0; clr_en = 0; clr_all = 0;
  endtask

  task automatic post(logic [2:0] c, logic [6:0] i); op(1, c, i, 0, 0, 0, 0); endtask
  task automatic clr(logic [2:0] c, logic [6:0] i);  op(0, 0, 0, 1, c, i, 0); endtask
  task automatic wipe(); op(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R3 reset any_pend", any_pend, 0);
    chk("R10 reset code", {trap_vld, trap_code}, 0);
    chk("R3 reset rd", rd_vec, 0);

    for (int k = 0; k < 14; k++) begin
      wipe();
      for (int c = 0; c < 7; c++) if (PRI[k][3+c]) post(3'(c), 7'(k));
      hpriv = PRI[k][11]; int_en = PRI[k][10];
      @(negedge clk);
      chk($sformatf("R8/R7 row %0d code", k), trap_code, PRI[k][2:0]);
      chk($sformatf("R10 row %0d vld", k), trap_vld, PRI[k][2:0] != 0);
      chk($sformatf("R6 row %0d pend", k), any_pend, PRI[k][9:3] != 0);
    end

    hpriv = 0; int_en = 1;
    for (int k = 0; k < 8; k++) begin
      wipe();
      for (int b = 0; b < 18; b++) if (LVL[k][4+b]) post(3'd5, 7'(b));
      chk($sformatf("R9 row %0d code", k), trap_code, 6);
      chk($sformatf("R9 row %0d level", k), sw_level, LVL[k][3:0]);
    end
    post(3'd3, 7'd0);
    chk("R9 level zero when not software", sw_level, 0);

    wipe(); rd_cls = 2;
    post(3'd2, 7'd63);
    chk("R1 rd bit 63", rd_vec, 64'h8000_0000_0000_0000);
    chk("R1 summary", summary, 7'h04);

    wipe(); rd_cls = 3;
    post(3'd3, 7'd5); post(3'd3, 7'd9);
    clr(3'd3, 7'd5);
    chk("R2 rd after one clear", rd_vec, 64'h200);
    chk("R2 summary kept", summary[3], 1);
    clr(3'd3, 7'd9);
    chk("R2 summary dropped", summary[3], 0);

    op(1, 3'd3, 7'd7, 1, 3'd3, 7'd7, 0);
    chk("R4 post wins", rd_vec, 64'h80);

    wipe();
    post(3'd7, 7'd1);
    chk("R5 class 7 ignored", any_pend, 0);
    post(3'd1, 7'd64);
    chk("R5 index 64 ignored", summary, 0);
    rd_cls = 7;
    chk("R5 read class 7", rd_vec, 0);
    rd_cls = 0; post(3'd0, 7'd1);
    clr(3'd0, 7'd65);
    chk("R5 illegal clear ignored", rd_vec, 64'h2);

    op(1, 3'd4, 7'd2, 0, 0, 0, 1);
    chk("R3 clear-all beats post", any_pend, 0);

    post(3'd6, 7'd0);
    hpriv = 1; int_en = 0;
    @(negedge clk);
    chk("R6 pend in gated mode", any_pend, 1);
    chk("R7 nothing raised", trap_code, 0);

    rst = 1; @(negedge clk); rst = 0;
    chk("R3 reset clears", summary, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule